// File: doc/BRIEF.md
# Text-Mode Character Fetch Pipeline

This block sits between the character memory of a text display and the dot stream that goes to the video mixer. A phase counter divides the dot clock by six and produces a latch strobe that is low for one dot clock in every six. When the strobe rises, the block captures a six-bit character code from memory together with three side-band bits: a graphic flag, an active-low blank flag and a row-gap flag. It also advances the memory address, so memory has a full six-dot window to settle before the next capture.

Memory stores only six code bits. The seventh code bit is rebuilt as the NOR of stored bit 5 and the graphic flag. The latched seven-bit code and the live scan-line count together form the glyph ROM address. On the dot clock after the capture, the serializer loads six dots. The dots come from the ROM for text cells, or from a 2x3 block-mosaic generator for graphic cells. The dots then shift out MSB first, one per dot clock. Blanking and row-gap gating are applied at load time, so the gating stays aligned with the character the dots belong to.

Top module: `char_fetch_pipe`

## Requirements
- R1: `strobe_no_o` is low for exactly one dot clock in every six. A capture happens on the clock edge that ends each low cycle.
- R2: While the latched data is valid, `rom_addr_o` is {bit6, code[5:0], scan[3:0]}: bit 10 is bit6, bits 9..4 are the latched code and bits 3..0 are the live `scan_line_i`. Bit6 is high only when stored code bit 5 and `gfx_bit_i` are both low.
- R3: Code, graphic, blank and row-gap inputs are sampled only at the capture edge. Changing them in any other cycle has no effect on the address or on the dots.
- R4: `vram_addr_o` is 0 after reset and increments by one at each capture edge. It holds its value at all other edges.
- R5: While `vclr_ni` is low at a clock edge, the latched code, bit6 and flags clear to zero. A cell captured under clear therefore produces the address {0, 0, scan} and six zero dots.
- R6: A cell latched with `blank_ni` low produces six zero dots.
- R7: A cell latched with `row_gap_i` high produces six zero dots.
- R8: A text cell drives `rom_data_i` out on `dot_o`, MSB first. The first dot appears in the second dot clock after the capture edge, and the cell lasts six dot clocks.
- R9: A graphic cell takes its band from `scan_line_i` divided by 4, clipped to 2. Its first three dots equal code bit 2*band and its last three equal code bit 2*band+1.
- R10: During reset, `dot_o` is 0, `strobe_no_o` is 1, and `vram_addr_o` and `rom_addr_o` are 0 with a zero scan line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vclr_ni | input | 1 | Latch clear, active low |
| vram_data_i | input | 6 | Stored character code bits |
| gfx_bit_i | input | 1 | Stored graphic flag (code bit 7) |
| blank_ni | input | 1 | Display enable; low blanks the cell |
| row_gap_i | input | 1 | High during scan lines between character rows |
| scan_line_i | input | 4 | Current scan line within the character row |
| rom_data_i | input | 6 | Glyph dot row returned by the ROM |
| strobe_no_o | output | 1 | Latch strobe, low one dot clock in six |
| vram_addr_o | output | 10 | Character memory address |
| rom_addr_o | output | 11 | Glyph ROM address |
| dot_o | output | 1 | Serial dot output |

## Verification
The bound checker watches four behaviours on every cycle: the six-clock strobe period, the address step on each capture, the rebuilt bit6 and the clear of the code field, and a rule that no dot is ever lit for a cell captured as blanked or in a row gap. Several behaviours can only be shown by the bench's scenarios, because they need a model of the cell: the exact dot order of text cells against a model glyph table, the band and half selection of graphic cells, and the insensitivity of the pipeline to input changes made just after the capture.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  typedef struct packed {
    logic gfx;
    logic blank_n;
    logic gap;
  } cell_flags_t;

  localparam int unsigned GFX_BAND_SH = 2;
endpackage

// File: rtl/cfp_timing.sv
module cfp_timing #(
  parameter int unsigned DOTS   = 6,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              cap_o,
  output logic              load_o,
  output logic              strobe_no_o,
  output logic [ADDR_W-1:0] vram_addr_o
);
  localparam int unsigned PH_W = $clog2(DOTS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DOTS - 1);

  logic [PH_W-1:0]   ph_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      addr_q <= '0;
    end else begin
      ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      if (ph_q == PH_LAST) addr_q <= addr_q + 1'b1;
    end
  end

  assign cap_o       = (ph_q == PH_LAST);
  assign load_o      = (ph_q == '0);
  assign strobe_no_o = ~cap_o;
  assign vram_addr_o = addr_q;
endmodule

// File: rtl/cfp_latch.sv
module cfp_latch
  import cfp_pkg::*;
#(
  parameter int unsigned CODE_BITS = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_ni,
  input  logic                 cap_i,
  input  logic [CODE_BITS-1:0] data_i,
  input  logic                 gfx_i,
  input  logic                 blank_ni,
  input  logic                 gap_i,
  output logic [CODE_BITS:0]   code_o,
  output cell_flags_t          flags_o
);
  logic        bit6;
  logic [CODE_BITS:0] code_q;
  cell_flags_t flags_q;

  // seventh bit rebuilt from stored bit 5 and the graphic bit
  assign bit6 = ~(data_i[CODE_BITS-1] | gfx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      flags_q <= '0;
    end else if (!clr_ni) begin
      code_q  <= '0;
      flags_q <= '0;
    end else if (cap_i) begin
      code_q  <= {bit6, data_i};
      flags_q <= '{gfx: gfx_i, blank_n: blank_ni, gap: gap_i};
    end
  end

  assign code_o  = code_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/cfp_serializer.sv
module cfp_serializer
  import cfp_pkg::*;
#(
  parameter int unsigned DOTS      = 6,
  parameter int unsigned CODE_BITS = 6,
  parameter int unsigned SCAN_W    = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [CODE_BITS-1:0] code_i,
  input  cell_flags_t          flags_i,
  input  logic [SCAN_W-1:0]    scan_i,
  input  logic [DOTS-1:0]      rom_data_i,
  output logic                 dot_o
);
  localparam int unsigned BANDS = CODE_BITS / 2;
  localparam int unsigned HALF  = DOTS / 2;
  localparam int unsigned BW    = SCAN_W;

  logic [BW-1:0]   band_raw;
  logic [BW-1:0]   band;
  logic            left_on;
  logic            right_on;
  logic [DOTS-1:0] gfx_row;
  logic [DOTS-1:0] src_row;
  logic [DOTS-1:0] sh_q;

  assign band_raw = scan_i >> GFX_BAND_SH;
  assign band     = (band_raw >= BW'(BANDS)) ? BW'(BANDS - 1) : band_raw;
  assign left_on  = code_i[2 * band];
  assign right_on = code_i[2 * band + 1];

  for (genvar j = 0; j < DOTS; j++) begin : g_mosaic
    if (j >= DOTS - HALF) begin : g_left
      assign gfx_row[j] = left_on;
    end else begin : g_right
      assign gfx_row[j] = right_on;
    end
  end

  // gate at load so the flags stay with their own cell
  assign src_row = (flags_i.blank_n && !flags_i.gap)
                 ? (flags_i.gfx ? gfx_row : rom_data_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= src_row;
    else             sh_q <= {sh_q[DOTS-2:0], 1'b0};
  end

  assign dot_o = sh_q[DOTS-1];
endmodule

// File: rtl/char_fetch_pipe.sv
module char_fetch_pipe
  import cfp_pkg::*;
#(
  parameter int unsigned DOTS      = 6,
  parameter int unsigned CODE_BITS = 6,
  parameter int unsigned SCAN_W    = 4,
  parameter int unsigned ADDR_W    = 10
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          vclr_ni,
  input  logic [CODE_BITS-1:0]          vram_data_i,
  input  logic                          gfx_bit_i,
  input  logic                          blank_ni,
  input  logic                          row_gap_i,
  input  logic [SCAN_W-1:0]             scan_line_i,
  input  logic [DOTS-1:0]               rom_data_i,
  output logic                          strobe_no_o,
  output logic [ADDR_W-1:0]             vram_addr_o,
  output logic [CODE_BITS+SCAN_W:0]     rom_addr_o,
  output logic                          dot_o
);
  logic               cap;
  logic               load;
  logic [CODE_BITS:0] code;
  cell_flags_t        flags;

  cfp_timing #(.DOTS(DOTS), .ADDR_W(ADDR_W)) u_timing (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_o       (cap),
    .load_o      (load),
    .strobe_no_o (strobe_no_o),
    .vram_addr_o (vram_addr_o)
  );

  cfp_latch #(.CODE_BITS(CODE_BITS)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_ni   (vclr_ni),
    .cap_i    (cap),
    .data_i   (vram_data_i),
    .gfx_i    (gfx_bit_i),
    .blank_ni (blank_ni),
    .gap_i    (row_gap_i),
    .code_o   (code),
    .flags_o  (flags)
  );

  assign rom_addr_o = {code, scan_line_i};

  cfp_serializer #(.DOTS(DOTS), .CODE_BITS(CODE_BITS), .SCAN_W(SCAN_W)) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .code_i     (code[CODE_BITS-1:0]),
    .flags_i    (flags),
    .scan_i     (scan_line_i),
    .rom_data_i (rom_data_i),
    .dot_o      (dot_o)
  );
endmodule

// File: rtl/cfp_checker.sv
module cfp_checker #(
  parameter int unsigned DOTS      = 6,
  parameter int unsigned CODE_BITS = 6,
  parameter int unsigned SCAN_W    = 4,
  parameter int unsigned ADDR_W    = 10
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      vclr_ni,
  input logic [CODE_BITS-1:0]      vram_data_i,
  input logic                      gfx_bit_i,
  input logic                      blank_ni,
  input logic                      row_gap_i,
  input logic                      strobe_no_o,
  input logic [ADDR_W-1:0]         vram_addr_o,
  input logic [CODE_BITS+SCAN_W:0] rom_addr_o,
  input logic                      dot_o
);
  localparam int unsigned TOP = CODE_BITS + SCAN_W;

  logic [7:0] since_q;
  logic       seen_q;
  logic       strobe_d_q;
  logic       blank_cap_q, gap_cap_q, blank_sh_q, gap_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q     <= '0;
      seen_q      <= 1'b0;
      strobe_d_q  <= 1'b0;
      blank_cap_q <= 1'b0;
      gap_cap_q   <= 1'b0;
      blank_sh_q  <= 1'b0;
      gap_sh_q    <= 1'b0;
    end else begin
      strobe_d_q <= !strobe_no_o;
      if (!strobe_no_o) begin
        since_q <= '0;
        seen_q  <= 1'b1;
      end else if (since_q != 8'hff) begin
        since_q <= since_q + 1'b1;
      end
      if (!vclr_ni) begin
        blank_cap_q <= 1'b0;
        gap_cap_q   <= 1'b0;
      end else if (!strobe_no_o) begin
        blank_cap_q <= blank_ni;
        gap_cap_q   <= row_gap_i;
      end
      if (strobe_d_q) begin
        blank_sh_q <= blank_cap_q;
        gap_sh_q   <= gap_cap_q;
      end
    end
  end

  assert_strobe_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_no_o && seen_q) |-> since_q == 8'(DOTS - 1));

  assert_strobe_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_no_o |=> strobe_no_o);

  assert_bit6_rebuild_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_no_o && vclr_ni) |=>
      rom_addr_o[TOP] == !($past(vram_data_i[CODE_BITS-1]) || $past(gfx_bit_i)));

  assert_code_field_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_no_o && vclr_ni) |=> rom_addr_o[TOP-1:SCAN_W] == $past(vram_data_i));

  assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_no_o |=> vram_addr_o == $past(vram_addr_o) + 1'b1);

  assert_addr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_no_o |=> $stable(vram_addr_o));

  assert_clear_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vclr_ni |=> rom_addr_o[TOP:SCAN_W] == '0);

  assert_blank_dark_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_o |-> blank_sh_q);

  assert_gap_dark_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dot_o |-> !gap_sh_q);
endmodule

bind char_fetch_pipe cfp_checker #(
  .DOTS(DOTS), .CODE_BITS(CODE_BITS), .SCAN_W(SCAN_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vclr_ni     (vclr_ni),
  .vram_data_i (vram_data_i),
  .gfx_bit_i   (gfx_bit_i),
  .blank_ni    (blank_ni),
  .row_gap_i   (row_gap_i),
  .strobe_no_o (strobe_no_o),
  .vram_addr_o (vram_addr_o),
  .rom_addr_o  (rom_addr_o),
  .dot_o       (dot_o)
);

// File: tb/char_fetch_pipe_test.sv
module char_fetch_pipe_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vclr_n = 1'b1;
  logic [5:0]  vdata = '0;
  logic        gfx = 1'b0;
  logic        blank_n = 1'b1;
  logic        gap = 1'b0;
  logic [3:0]  scan = '0;
  logic [5:0]  rom_data;
  logic        strobe_n;
  logic [9:0]  vaddr;
  logic [10:0] rom_addr;
  logic        dot;

  int checks = 0;
  int fails  = 0;
  logic [5:0] exp_q[$];

  always #2.5 clk = ~clk;

  char_fetch_pipe uut (
    .clk_i(clk), .rst_ni(rst_n), .vclr_ni(vclr_n), .vram_data_i(vdata),
    .gfx_bit_i(gfx), .blank_ni(blank_n), .row_gap_i(gap), .scan_line_i(scan),
    .rom_data_i(rom_data), .strobe_no_o(strobe_n), .vram_addr_o(vaddr),
    .rom_addr_o(rom_addr), .dot_o(dot)
  );

  function automatic logic [5:0] glyph(input logic [10:0] a);
    logic [10:0] m;
    m = (a * 11'd29) >> 2;
    return m[5:0] ^ a[10:5];
  endfunction

  assign rom_data = glyph(rom_addr);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] mosaic(input logic [5:0] c, input logic [3:0] s);
    int b;
    b = s / 4;
    if (b > 2) b = 2;
    return {{3{c[2*b]}}, {3{c[2*b+1]}}};
  endfunction

  // driver: called at a negedge in phase 1 (or just after reset)
  task automatic send(input logic [5:0] c, input logic g, input logic bn,
                      input logic gp, input logic cl, input logic [3:0] s,
                      input string req);
    logic [10:0] ea;
    logic [9:0]  a0;
    logic [5:0]  ed;
    vdata = c; gfx = g; blank_n = bn; gap = gp; vclr_n = cl; scan = s;
    do @(negedge clk); while (strobe_n !== 1'b0);
    a0 = vaddr;
    ea = cl ? {~(c[5] | g), c, s} : {7'b0, s};
    if (!cl || !bn || gp) ed = '0;
    else if (g)           ed = mosaic(c, s);
    else                  ed = glyph(ea);
    exp_q.push_back(ed);
    @(negedge clk);
    // scramble inputs after capture: must not matter (R3)
    vdata = ~c; gfx = ~g; blank_n = ~bn; gap = ~gp; vclr_n = 1'b1;
    #1;
    check({req, " R2 rom_addr"}, 32'(rom_addr), 32'(ea));
    check("R4 vram_addr step", 32'(vaddr), 32'(a0 + 10'd1));
    @(negedge clk);
  endtask

  // monitor: scoreboard on dot_o
  initial begin
    logic [5:0] cur, nxt;
    int slot;
    bit armed, prev_low;
    slot = -1; armed = 0; prev_low = 0; cur = '0; nxt = '0;
    forever begin
      @(negedge clk);
      #1;
      if (armed) begin cur = nxt; slot = 0; armed = 0; end
      if (slot >= 0) begin
        check("R8/R9 dot stream (R3 R5 R6 R7 gating)", 32'(dot), 32'(cur[5 - slot]));
        slot++;
        if (slot == 6) slot = -1;
      end
      if (prev_low && exp_q.size() > 0) begin nxt = exp_q.pop_front(); armed = 1; end
      prev_low = (strobe_n === 1'b0);
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int lows;
    repeat (3) @(negedge clk);
    check("R10 dot in reset", 32'(dot), 0);
    check("R10 strobe in reset", 32'(strobe_n), 1);
    check("R10 vram_addr in reset", 32'(vaddr), 0);
    check("R10 rom_addr in reset", 32'(rom_addr), 0);
    rst_n = 1'b1;
    // R1: strobe low 10 times in 60 dot clocks
    lows = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (strobe_n === 1'b0) lows++;
    end
    check("R1 strobe count", 32'(lows), 10);
    do @(negedge clk); while (strobe_n !== 1'b0);
    @(negedge clk); @(negedge clk);
    // text cells, bit6 derivation both ways (R2, R8)
    send(6'h01, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, "R8 text bit6=1");
    send(6'h21, 1'b0, 1'b1, 1'b0, 1'b1, 4'd3, "R8 text bit5 set");
    send(6'h3f, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7, "R8 text all ones");
    send(6'h15, 1'b0, 1'b1, 1'b0, 1'b1, 4'd11, "R8 text");
    // graphic cells over every band including clip (R9)
    send(6'b100110, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0, "R9 gfx band0");
    send(6'b011001, 1'b1, 1'b1, 1'b0, 1'b1, 4'd5, "R9 gfx band1");
    send(6'b101101, 1'b1, 1'b1, 1'b0, 1'b1, 4'd9, "R9 gfx band2");
    send(6'b010010, 1'b1, 1'b1, 1'b0, 1'b1, 4'd13, "R9 gfx clip");
    // blanking and row gap (R6, R7)
    send(6'h3f, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, "R6 blank text");
    send(6'h3f, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2, "R6 blank gfx");
    send(6'h0f, 1'b0, 1'b1, 1'b1, 1'b1, 4'd4, "R7 gap text");
    send(6'h3f, 1'b1, 1'b1, 1'b1, 1'b1, 4'd8, "R7 gap gfx");
    // clear (R5) then recovery
    send(6'h2a, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6, "R5 clear");
    send(6'h2a, 1'b0, 1'b1, 1'b0, 1'b1, 4'd6, "R8 after clear");
    for (int k = 0; k < 20; k++)
      send(6'(k * 7 + 3), k[0], 1'b1, 1'b0, 1'b1, 4'(k % 12), "R8/R9 sweep");
    repeat (12) @(negedge clk);
    check("R8 scoreboard drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule